// File: doc/BRIEF.md
# ATA Pass-Through Command Block Interpreter

This block receives the 16-byte command block that travels inside a mass-storage command wrapper, one byte per clock under a valid/ready handshake. When the last byte arrives, it decides whether the block is an ATA pass-through command or an ordinary command. A block counts as pass-through only when it is exactly 16 bytes long, its first byte equals a signature value taken from start-up configuration, and its second byte is the fixed sub-command code 0x24. The result is reported as a one-cycle classification pulse.

For a pass-through command, the block keeps the per-command action flags from byte 2 and works out the device-select bit. It then runs a short control sequence. If polling is not skipped, it reads the device's alternate-status register through a simple request/acknowledge port and repeats the read until the busy bit clears, or until a programmable limit of busy reads is reached. Next it fires an execute strobe that carries the transfer mode, the IDENTIFY marker and the device bit. Last, it supervises the data phase: unless the command's override flags say otherwise, a device error or a phase error ends the phase in a halt with a reported cause.

The USB protocol, the ATA bus timing and the movement of data are handled elsewhere.

Top module: `ata_cb_interp`

## Requirements
- R1: After synchronous reset the block is idle. `inReady` is 1, every strobe and pulse output is 0, and `haltCause` is 0.
- R2: One cycle after the byte marked with `inLast` is accepted, `clsValid` is high for exactly one cycle. On that pulse, `clsIsAta` is 1 only if byte 0 equals `cfgSignature` and byte 1 equals 0x24. A block that is not pass-through returns the block to idle with no further strobes.
- R3: A block whose length, counted up to and including the `inLast` byte, is not exactly 16 is classified as ordinary, even when its first two bytes match.
- R4: `inReady` is 1 only while idle or while collecting bytes. Bytes offered at any other time are not taken and do not change the sequence in progress.
- R5: When bit 2 of byte 2 is 0, the block raises `regRdReq` for one cycle and then waits for `regRdAck`. If bit 7 of `regRdData` is 1 on the acknowledge, it issues a new request. If bit 7 is 0, it moves on to execution.
- R6: If the number of busy responses reaches `pollLimit` (a limit of 0 acts as 1), `halted` pulses for one cycle with `haltCause` = 3 (timeout), and no execute strobe follows.
- R7: When bit 2 of byte 2 is 1, `execStrobe` follows the classification pulse in the next cycle, and no register read is requested.
- R8: `execStrobe` is a one-cycle pulse. While it is high, `execUdma` equals bit 6 of byte 2 and `execIdentify` equals bit 7 of byte 2.
- R9: While `execStrobe` is high, `execDev` equals bit 4 of byte 11 if bit 5 of byte 2 is 1. Otherwise it equals `lunDevBit` as sampled in the classification cycle.
- R10: During the data phase, `devErr` with bit 4 of byte 2 at 0 leads to a one-cycle `halted` pulse with `haltCause` = 1. With bit 4 at 1, the device error is ignored.
- R11: `phaseErr` with bit 3 of byte 2 at 0 halts the data phase with `haltCause` = 2. With bit 3 at 1, the phase error is ignored. If both errors would halt in the same cycle, the cause reported is 1.
- R12: `dataDone` with no halting error in the same cycle gives a one-cycle `doneOk` pulse and a return to idle. A halting error in the same cycle takes precedence over completion. `haltCause` holds its value until the next block starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgSignature | input | 8 | Start-up signature value matched against byte 0 |
| lunDevBit | input | 1 | Start-up device bit for the addressed LUN |
| pollLimit | input | 16 | Number of busy status reads that ends polling with a timeout |
| inValid | input | 1 | Command byte valid |
| inData | input | 8 | Command byte |
| inLast | input | 1 | Marks the final byte of the block |
| inReady | output | 1 | Block can take a byte |
| clsValid | output | 1 | Classification pulse |
| clsIsAta | output | 1 | Block is an ATA pass-through command (valid with clsValid) |
| regRdReq | output | 1 | Alternate-status read request pulse |
| regRdAck | input | 1 | Read response valid |
| regRdData | input | 8 | Read response data, bit 7 is busy |
| execStrobe | output | 1 | Execute pulse |
| execUdma | output | 1 | Transfer mode: 1 UDMA, 0 PIO |
| execIdentify | output | 1 | Data phase carries IDENTIFY data |
| execDev | output | 1 | Resolved device-select bit |
| dataDone | input | 1 | Data phase finished |
| devErr | input | 1 | Device error seen in data phase |
| phaseErr | input | 1 | Phase error seen in data phase |
| doneOk | output | 1 | Command completed pulse |
| halted | output | 1 | Command halted pulse |
| haltCause | output | 2 | 0 none, 1 device error, 2 phase error, 3 poll timeout |

## Verification
In the data phase, completion and the error checks are evaluated in the same cycle, and device and phase errors can also coincide with each other. The bench raises `dataDone` together with `devErr`, and also both errors together, under different override settings. In that cycle it holds `inValid` high to test that the busy block ignores new bytes. A reference model is stepped each clock, and it expects the halt to win over completion, the device error to win over the phase error, and overridden errors to leave the phase running until completion.

// File: rtl/ata_cb_pkg.sv
package ata_cb_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_COLLECT, S_CLASSIFY, S_POLL_REQ, S_POLL_WAIT,
    S_EXECUTE, S_DATA, S_DONE, S_HALT
  } cbStateT;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_DEV   = 2'd1;
  localparam logic [1:0] CAUSE_PHASE = 2'd2;
  localparam logic [1:0] CAUSE_TMO   = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       startBlk;
    logic       takeByte;
    logic       latchDev;
    logic       pollClr;
    logic       pollInc;
    logic       setCause;
    logic [1:0] causeCode;
  } ctlStrobeT;

endpackage

// File: rtl/ata_cb_dpath.sv
module ata_cb_dpath
  import ata_cb_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int CB_LEN   = 16,
  parameter int POLL_W   = 16,
  parameter int SUB_CMD  = 8'h24,
  parameter int ACT_IDX  = 2,
  parameter int DEV_IDX  = 11,
  parameter int DEV_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobeT         stb,
  input  logic [BYTE_W-1:0] inData,
  input  logic [BYTE_W-1:0] cfgSignature,
  input  logic              lunDevBit,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              isAta,
  output logic [BYTE_W-1:0] actFlags,
  output logic              lastBusy,
  output logic              devBit,
  output logic [1:0]        cause
);

  localparam int CNT_W   = $clog2(CB_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CB_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CB_LEN);

  logic [CNT_W-1:0]  byteCnt;
  logic              sigOk, subOk, devField;
  logic [POLL_W-1:0] pollCnt;
  logic [POLL_W:0]   limitEff;

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt  <= '0;
      sigOk    <= 1'b0;
      subOk    <= 1'b0;
      actFlags <= '0;
      devField <= 1'b0;
    end else if (stb.startBlk) begin
      byteCnt  <= CNT_W'(1);
      sigOk    <= (inData == cfgSignature);
      subOk    <= 1'b0;
      actFlags <= '0;
      devField <= 1'b0;
    end else if (stb.takeByte) begin
      if (byteCnt != CNT_SAT) byteCnt <= byteCnt + 1'b1;
      if (byteCnt == CNT_W'(1))       subOk    <= (inData == BYTE_W'(SUB_CMD));
      if (byteCnt == CNT_W'(ACT_IDX)) actFlags <= inData;
      if (byteCnt == CNT_W'(DEV_IDX)) devField <= inData[DEV_BIT];
    end
  end

  assign isAta = sigOk && subOk && (byteCnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      devBit <= 1'b0;
    end else if (stb.latchDev) begin
      devBit <= actFlags[5] ? devField : lunDevBit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.pollClr) pollCnt <= '0;
    else if (stb.pollInc)   pollCnt <= pollCnt + 1'b1;
  end

  assign limitEff = (pollLimit == '0) ? (POLL_W+1)'(1) : {1'b0, pollLimit};
  assign lastBusy = ({1'b0, pollCnt} + (POLL_W+1)'(1)) >= limitEff;

  always_ff @(posedge clk) begin
    if (rst || stb.startBlk) cause <= CAUSE_NONE;
    else if (stb.setCause)   cause <= stb.causeCode;
  end

endmodule

// File: rtl/ata_cb_ctrl.sv
module ata_cb_ctrl
  import ata_cb_pkg::*;
#(
  parameter int BUSY_BIT = 7
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      isAta,
  input  logic [7:0] actFlags,
  input  logic      lastBusy,
  input  logic      regRdAck,
  input  logic [7:0] regRdData,
  input  logic      dataDone,
  input  logic      devErr,
  input  logic      phaseErr,
  output ctlStrobeT stb,
  output logic      inReady,
  output logic      clsValid,
  output logic      regRdReq,
  output logic      execStrobe,
  output logic      doneOk,
  output logic      halted
);

  cbStateT state, nextState;
  logic    accept, devHalt, phHalt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  assign inReady    = (state == S_IDLE) || (state == S_COLLECT);
  assign accept     = inValid && inReady;
  assign clsValid   = (state == S_CLASSIFY);
  assign regRdReq   = (state == S_POLL_REQ);
  assign execStrobe = (state == S_EXECUTE);
  assign doneOk     = (state == S_DONE);
  assign halted     = (state == S_HALT);
  assign devHalt    = devErr && !actFlags[4];
  assign phHalt     = phaseErr && !actFlags[3];

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      S_IDLE: if (accept) begin
        stb.startBlk = 1'b1;
        stb.takeByte = 1'b1;
        nextState    = inLast ? S_CLASSIFY : S_COLLECT;
      end
      S_COLLECT: if (accept) begin
        stb.takeByte = 1'b1;
        if (inLast) nextState = S_CLASSIFY;
      end
      S_CLASSIFY: begin
        stb.latchDev = 1'b1;
        stb.pollClr  = 1'b1;
        if (!isAta)           nextState = S_IDLE;
        else if (actFlags[2]) nextState = S_EXECUTE;
        else                  nextState = S_POLL_REQ;
      end
      S_POLL_REQ: nextState = S_POLL_WAIT;
      S_POLL_WAIT: if (regRdAck) begin
        if (regRdData[BUSY_BIT]) begin
          stb.pollInc = 1'b1;
          if (lastBusy) begin
            stb.setCause  = 1'b1;
            stb.causeCode = CAUSE_TMO;
            nextState     = S_HALT;
          end else begin
            nextState = S_POLL_REQ;
          end
        end else begin
          nextState = S_EXECUTE;
        end
      end
      S_EXECUTE: nextState = S_DATA;
      S_DATA: begin
        if (devHalt) begin
          stb.setCause  = 1'b1;
          stb.causeCode = CAUSE_DEV;
          nextState     = S_HALT;
        end else if (phHalt) begin
          stb.setCause  = 1'b1;
          stb.causeCode = CAUSE_PHASE;
          nextState     = S_HALT;
        end else if (dataDone) begin
          nextState = S_DONE;
        end
      end
      S_DONE:  nextState = S_IDLE;
      S_HALT:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/ata_cb_interp.sv
module ata_cb_interp
  import ata_cb_pkg::*;
#(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cfgSignature,
  input  logic              lunDevBit,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              clsValid,
  output logic              clsIsAta,
  output logic              regRdReq,
  input  logic              regRdAck,
  input  logic [7:0]        regRdData,
  output logic              execStrobe,
  output logic              execUdma,
  output logic              execIdentify,
  output logic              execDev,
  input  logic              dataDone,
  input  logic              devErr,
  input  logic              phaseErr,
  output logic              doneOk,
  output logic              halted,
  output logic [1:0]        haltCause
);

  ctlStrobeT  stb;
  logic       isAta, lastBusy, devBit;
  logic [7:0] actFlags;

  ata_cb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .isAta(isAta), .actFlags(actFlags), .lastBusy(lastBusy),
    .regRdAck(regRdAck), .regRdData(regRdData), .dataDone(dataDone),
    .devErr(devErr), .phaseErr(phaseErr), .stb(stb), .inReady(inReady),
    .clsValid(clsValid), .regRdReq(regRdReq), .execStrobe(execStrobe),
    .doneOk(doneOk), .halted(halted)
  );

  ata_cb_dpath #(.POLL_W(POLL_W)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .inData(inData),
    .cfgSignature(cfgSignature), .lunDevBit(lunDevBit),
    .pollLimit(pollLimit), .isAta(isAta), .actFlags(actFlags),
    .lastBusy(lastBusy), .devBit(devBit), .cause(haltCause)
  );

  assign clsIsAta     = clsValid && isAta;
  assign execUdma     = actFlags[6];
  assign execIdentify = actFlags[7];
  assign execDev      = devBit;

endmodule

// File: rtl/ata_cb_chk.sv
module ata_cb_chk (
  input logic       clk,
  input logic       rst,
  input logic       inReady,
  input logic       clsValid,
  input logic       clsIsAta,
  input logic       regRdReq,
  input logic       regRdAck,
  input logic       execStrobe,
  input logic       doneOk,
  input logic       halted,
  input logic [1:0] haltCause
);

  // R2
  cls_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    clsValid |=> !clsValid);

  // R2
  cls_qual_chk: assert property (@(posedge clk) disable iff (rst)
    clsIsAta |-> clsValid);

  // R4
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    inReady |-> !(regRdReq || execStrobe || doneOk || halted || clsValid));

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    regRdReq |=> !regRdReq);

  // R6
  tmo_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && haltCause == 2'd3) |-> $past(regRdAck));

  // R7
  exec_origin_chk: assert property (@(posedge clk) disable iff (rst)
    execStrobe |-> $past(clsIsAta || regRdAck));

  // R8
  exec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    execStrobe |=> !execStrobe);

  // R12
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    doneOk |-> !halted);

endmodule

bind ata_cb_interp ata_cb_chk u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .clsValid(clsValid),
  .clsIsAta(clsIsAta), .regRdReq(regRdReq), .regRdAck(regRdAck),
  .execStrobe(execStrobe), .doneOk(doneOk), .halted(halted),
  .haltCause(haltCause)
);

// File: tb/sim_ata_cb_interp.sv
module sim_ata_cb_interp;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfgSignature = 8'h5A;
  logic        lunDevBit = 1'b0;
  logic [15:0] pollLimit = 16'd3;
  logic        inValid = 1'b0, inLast = 1'b0;
  logic [7:0]  inData = '0;
  logic        inReady, clsValid, clsIsAta, regRdReq;
  logic        regRdAck = 1'b0;
  logic [7:0]  regRdData = '0;
  logic        execStrobe, execUdma, execIdentify, execDev;
  logic        dataDone = 1'b0, devErr = 1'b0, phaseErr = 1'b0;
  logic        doneOk, halted;
  logic [1:0]  haltCause;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ata_cb_interp u0 (
    .clk(clk), .rst(rst), .cfgSignature(cfgSignature), .lunDevBit(lunDevBit),
    .pollLimit(pollLimit), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .clsValid(clsValid), .clsIsAta(clsIsAta),
    .regRdReq(regRdReq), .regRdAck(regRdAck), .regRdData(regRdData),
    .execStrobe(execStrobe), .execUdma(execUdma), .execIdentify(execIdentify),
    .execDev(execDev), .dataDone(dataDone), .devErr(devErr),
    .phaseErr(phaseErr), .doneOk(doneOk), .halted(halted),
    .haltCause(haltCause)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every output in a quiet cycle of the given phase
  task automatic chkQuiet(input string tag, input bit rdy);
    chk({tag, " inReady"}, inReady, rdy);
    chk({tag, " clsValid"}, clsValid, 0);
    chk({tag, " regRdReq"}, regRdReq, 0);
    chk({tag, " execStrobe"}, execStrobe, 0);
    chk({tag, " doneOk"}, doneOk, 0);
    chk({tag, " halted"}, halted, 0);
  endtask

  function automatic logic [7:0] cbByte(input int i, input logic [7:0] b0,
      input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b11);
    case (i)
      0: return b0;
      1: return b1;
      2: return b2;
      11: return b11;
      default: return 8'(i * 3 + 1);
    endcase
  endfunction

  // evt bit0 done, bit1 device error, bit2 phase error
  task automatic runCmd(input int len, input logic [7:0] b0, input logic [7:0] b1,
      input logic [7:0] b2, input logic [7:0] b11, input bit lun,
      input int busyReads, input int evt);
    bit expAta, stop, devH, phH;
    int limEff;
    expAta = (len == 16) && (b0 == cfgSignature) && (b1 == 8'h24);
    limEff = (pollLimit == 0) ? 1 : int'(pollLimit);
    lunDevBit = lun;
    chkQuiet("R4 idle before block", 1);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = cbByte(i, b0, b1, b2, b11);
      inLast  = (i == len - 1);
      @(negedge clk);
      if (i < len - 1) chkQuiet("R4 collecting", 1);
    end
    inValid = 1'b0; inLast = 1'b0;
    chk("R2 clsValid pulse", clsValid, 1);
    chk(len == 16 ? "R2 clsIsAta" : "R3 length rule", clsIsAta, expAta);
    chk("R4 not ready in classify", inReady, 0);
    chk("R12 cause cleared on new block", haltCause, 0);
    @(negedge clk);
    if (!expAta) begin
      chkQuiet("R2 ordinary returns idle", 1);
      return;
    end
    stop = 0;
    if (!b2[2]) begin
      for (int k = 0; !stop; k++) begin
        chk("R5 regRdReq", regRdReq, 1);
        chk("R5 no exec while polling", execStrobe, 0);
        @(negedge clk);
        chk("R5 request is one pulse", regRdReq, 0);
        regRdAck  = 1'b1;
        regRdData = (k < busyReads) ? 8'h80 : 8'h13;
        @(negedge clk);
        regRdAck = 1'b0; regRdData = '0;
        if (k < busyReads) begin
          if (k + 1 >= limEff) begin
            chk("R6 timeout halted", halted, 1);
            chk("R6 timeout cause", haltCause, 3);
            chk("R6 no exec", execStrobe, 0);
            @(negedge clk);
            chkQuiet("R6 back to idle", 1);
            return;
          end
        end else begin
          stop = 1;
        end
      end
    end else begin
      chk("R7 no regRdReq", regRdReq, 0);
    end
    chk(b2[2] ? "R7 exec after classify" : "R5 exec after ready", execStrobe, 1);
    chk("R8 execUdma", execUdma, b2[6]);
    chk("R8 execIdentify", execIdentify, b2[7]);
    chk("R9 execDev", execDev, b2[5] ? b11[4] : lun);
    @(negedge clk);
    chkQuiet("R8 exec one pulse", 0);
    // data phase: events together with a byte offered (R4 ignore)
    inValid = 1'b1; inData = 8'hFF; inLast = 1'b1;
    dataDone = evt[0]; devErr = evt[1]; phaseErr = evt[2];
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    dataDone = 1'b0; devErr = 1'b0; phaseErr = 1'b0;
    devH = evt[1] && !b2[4];
    phH  = evt[2] && !b2[3];
    chk("R4 byte ignored in data phase", clsValid, 0);
    if (devH || phH) begin
      chk("R10/R11 halted", halted, 1);
      chk(devH ? "R10 cause device" : "R11 cause phase", haltCause, devH ? 1 : 2);
      chk("R12 halt beats done", doneOk, 0);
    end else if (evt[0]) begin
      chk("R12 doneOk", doneOk, 1);
      chk("R12 not halted", halted, 0);
    end else begin
      chkQuiet("R10/R11 overridden error ignored", 0);
      dataDone = 1'b1;
      @(negedge clk);
      dataDone = 1'b0;
      chk("R12 doneOk after override", doneOk, 1);
      chk("R12 cause none", haltCause, 0);
    end
    @(negedge clk);
    chkQuiet("R12 back to idle", 1);
    if (devH || phH) chk("R12 cause held", haltCause, devH ? 1 : 2);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R1: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chkQuiet("R1 reset state", 1);
    chk("R1 haltCause", haltCause, 0);
    chk("R1 clsIsAta", clsIsAta, 0);
    // skip poll, UDMA, device from LUN
    runCmd(16, 8'h5A, 8'h24, 8'h44, 8'h00, 1'b1, 0, 1);
    // poll two busy, identify, device override from byte 11, device error
    runCmd(16, 8'h5A, 8'h24, 8'hA0, 8'h10, 1'b0, 2, 2);
    // poll timeout at limit 3
    runCmd(16, 8'h5A, 8'h24, 8'h00, 8'h00, 1'b0, 5, 1);
    // ordinary: wrong sub-command, wrong signature, wrong lengths
    runCmd(16, 8'h5A, 8'h25, 8'h04, 8'h00, 1'b0, 0, 1);
    runCmd(16, 8'h11, 8'h24, 8'h04, 8'h00, 1'b0, 0, 1);
    runCmd(15, 8'h5A, 8'h24, 8'h04, 8'h00, 1'b0, 0, 1);
    runCmd(17, 8'h5A, 8'h24, 8'h04, 8'h00, 1'b0, 0, 1);
    // phase error overridden, then completion
    runCmd(16, 8'h5A, 8'h24, 8'h0C, 8'h00, 1'b0, 0, 4);
    // both errors: device wins; with device override phase halts
    runCmd(16, 8'h5A, 8'h24, 8'h04, 8'h00, 1'b1, 0, 6);
    runCmd(16, 8'h5A, 8'h24, 8'h14, 8'h00, 1'b1, 0, 6);
    // completion and device error together: halt wins, overridden completes
    runCmd(16, 8'h5A, 8'h24, 8'h24, 8'hEF, 1'b1, 0, 3);
    runCmd(16, 8'h5A, 8'h24, 8'h14, 8'h00, 1'b0, 1, 3);
    // limit 0 acts as 1
    pollLimit = 16'd0;
    runCmd(16, 8'h5A, 8'h24, 8'h00, 8'h00, 1'b0, 1, 1);
    pollLimit = 16'd3;
    // new signature value
    cfgSignature = 8'hC3;
    runCmd(16, 8'hC3, 8'h24, 8'h04, 8'h00, 1'b0, 0, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule